// File: doc/BRIEF.md
# Show Cycle Bus Controller

This block sits between the processor's internal transfer path and the external bus. It decides what the external bus does while an internal transfer runs. A two-bit mode field controls three things. It sets whether internal transfers are mirrored onto the external pins as show cycles, so that an outside observer can trace them. It sets whether an external master may take the bus. It also sets whether internal activity must stop while such a master holds the bus.

Each internal transfer is a single-cycle strobe that carries an address, data and a direction. When mirroring is enabled, the block registers that transfer. In the next cycle it presents the transfer on the external address and data lines, with the drive enables and a one-cycle show strobe. An external request is answered with a grant only at a transfer boundary. The grant is held for as long as the request stays high. The external drivers are never enabled while a grant is out. In the halting mode, a halt request accompanies the grant. The mode field is sampled only between transfers.

Top module: `showcyc_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, show_stb, ext_addr_oe, ext_data_oe, ext_grant and int_halt are all 0, and the active mode is 00.
- R2: In mode 00, an internal transfer produces no show strobe and no drive enables.
- R3: In modes 01, 10 and 11 with no grant held, a transfer sampled at a clock edge raises show_stb, ext_addr_oe and ext_data_oe for exactly the following cycle. In that cycle ext_addr and ext_data equal the sampled address and data, and ext_write equals the sampled direction (1 = write).
- R4: In mode 01, ext_grant never asserts, whatever ext_req does.
- R5: In modes 00, 10 and 11, ext_req sampled high in a cycle with no transfer strobe and no show cycle in progress raises ext_grant in the next cycle. ext_grant stays high while ext_req stays high, and falls in the cycle after ext_req is sampled low.
- R6: A grant is never started in a cycle where a transfer strobe is present or a show cycle is being driven. The grant follows at the first idle boundary.
- R7: The drive enables are never high while ext_grant is high. A transfer that arrives while a grant is held is not mirrored.
- R8: In mode 11, int_halt rises in the same cycle as ext_grant and falls with it, one cycle after ext_req is removed. In the other modes int_halt stays 0.
- R9: A new mode value is adopted only at a clock edge where no transfer strobe is present and no show cycle is in progress. When the active mode becomes 01, a held grant is withdrawn in the next cycle.
- R10: Back-to-back transfers in a show mode give one show strobe cycle per transfer. Each strobe cycle carries its own transfer's address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Requested show/arbitration mode |
| xfer_valid | input | 1 | Internal transfer strobe, one cycle per transfer |
| xfer_addr | input | ADDR_W | Internal transfer address |
| xfer_data | input | DATA_W | Internal transfer data |
| xfer_write | input | 1 | Internal transfer direction, 1 = write |
| ext_req | input | 1 | External master bus request |
| ext_addr | output | ADDR_W | Mirrored address |
| ext_data | output | DATA_W | Mirrored data |
| ext_write | output | 1 | Mirrored direction |
| ext_addr_oe | output | 1 | External address drive enable |
| ext_data_oe | output | 1 | External data drive enable |
| show_stb | output | 1 | One-cycle show cycle strobe |
| ext_grant | output | 1 | Bus grant to the external master |
| int_halt | output | 1 | Request to stall internal activity |

## Verification
The bench builds the controller with a 12-bit address and 8-bit data. These widths keep the mirrored values readable in the vector table, while the address and data paths stay separate from the control fields. The reset mode stays at its default of 00, so the first table rows exercise the no-mirror case before any mode write. With small widths, every mode pairing can be reached in a short run. This covers mode changes blocked by a transfer or by a show cycle, a request arriving alongside a strobe, and a grant withdrawn when the mode switches to 01.

// File: rtl/showcyc_pkg.sv
package showcyc_pkg;

  typedef enum logic [1:0] {
    SC_OFF      = 2'b00,
    SC_NOARB    = 2'b01,
    SC_ARB      = 2'b10,
    SC_ARB_HALT = 2'b11
  } sc_mode_e;

  function automatic logic mode_mirrors(input sc_mode_e m);
    return (m != SC_OFF);
  endfunction

  function automatic logic mode_arbitrates(input sc_mode_e m);
    return (m != SC_NOARB);
  endfunction

  function automatic logic mode_halts(input sc_mode_e m);
    return (m == SC_ARB_HALT);
  endfunction

endpackage

// File: rtl/showcyc_mode_reg.sv
module showcyc_mode_reg
  import showcyc_pkg::*;
#(
  parameter logic [1:0] RESET_MODE = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_in,
  input  logic       xfer_valid,
  input  logic       show_busy,
  output logic [1:0] mode_q,
  output logic       mirror_en,
  output logic       arb_en,
  output logic       halt_en
);

  logic       mode_ce;
  sc_mode_e   mode_cur;

  // Mode is adopted only in a gap between transfers.
  always_comb begin
    mode_ce = !xfer_valid && !show_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RESET_MODE;
    end else if (mode_ce) begin
      mode_q <= mode_in;
    end
  end

  always_comb begin
    mode_cur  = sc_mode_e'(mode_q);
    mirror_en = mode_mirrors(mode_cur);
    arb_en    = mode_arbitrates(mode_cur);
    halt_en   = mode_halts(mode_cur);
  end

endmodule

// File: rtl/showcyc_mirror.sv
module showcyc_mirror #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_valid,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [DATA_W-1:0] xfer_data,
  input  logic              xfer_write,
  input  logic              mirror_en,
  input  logic              grant_q,
  output logic              show_q,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_write
);

  logic launch;

  always_comb begin
    launch = xfer_valid && mirror_en && !grant_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      show_q <= 1'b0;
    end else begin
      show_q <= launch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr  <= '0;
      cap_data  <= '0;
      cap_write <= 1'b0;
    end else if (launch) begin
      cap_addr  <= xfer_addr;
      cap_data  <= xfer_data;
      cap_write <= xfer_write;
    end
  end

endmodule

// File: rtl/showcyc_arbiter.sv
module showcyc_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req,
  input  logic arb_en,
  input  logic halt_en,
  input  logic xfer_valid,
  input  logic show_busy,
  output logic grant_q,
  output logic halt_req
);

  logic boundary;
  logic grant_d;

  always_comb begin
    boundary = !xfer_valid && !show_busy;
    grant_d  = ext_req && arb_en && (grant_q || boundary);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
    end else begin
      grant_q <= grant_d;
    end
  end

  always_comb begin
    halt_req = grant_q && halt_en;
  end

endmodule

// File: rtl/showcyc_ctrl.sv
module showcyc_ctrl #(
  parameter int         ADDR_W     = 24,
  parameter int         DATA_W     = 16,
  parameter logic [1:0] RESET_MODE = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              xfer_valid,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [DATA_W-1:0] xfer_data,
  input  logic              xfer_write,
  input  logic              ext_req,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_data,
  output logic              ext_write,
  output logic              ext_addr_oe,
  output logic              ext_data_oe,
  output logic              show_stb,
  output logic              ext_grant,
  output logic              int_halt
);

  logic [1:0] mode_q;
  logic       mirror_en;
  logic       arb_en;
  logic       halt_en;
  logic       show_q;
  logic       grant_q;
  logic       halt_req;

  showcyc_mode_reg #(.RESET_MODE(RESET_MODE)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_in   (mode_sel),
    .xfer_valid(xfer_valid),
    .show_busy (show_q),
    .mode_q    (mode_q),
    .mirror_en (mirror_en),
    .arb_en    (arb_en),
    .halt_en   (halt_en)
  );

  showcyc_mirror #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mirror (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_valid(xfer_valid),
    .xfer_addr (xfer_addr),
    .xfer_data (xfer_data),
    .xfer_write(xfer_write),
    .mirror_en (mirror_en),
    .grant_q   (grant_q),
    .show_q    (show_q),
    .cap_addr  (ext_addr),
    .cap_data  (ext_data),
    .cap_write (ext_write)
  );

  showcyc_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_req   (ext_req),
    .arb_en    (arb_en),
    .halt_en   (halt_en),
    .xfer_valid(xfer_valid),
    .show_busy (show_q),
    .grant_q   (grant_q),
    .halt_req  (halt_req)
  );

  always_comb begin
    ext_addr_oe = show_q;
    ext_data_oe = show_q;
    show_stb    = show_q;
    ext_grant   = grant_q;
    int_halt    = halt_req;
  end

endmodule

// File: rtl/showcyc_ctrl_chk.sv
module showcyc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_valid,
  input logic       show_stb,
  input logic       ext_addr_oe,
  input logic       ext_data_oe,
  input logic       ext_grant,
  input logic       int_halt,
  input logic [1:0] mode_cur
);

  // R7: drivers off whenever an external master owns the bus
  assert_oe_excl_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !((ext_addr_oe || ext_data_oe) && ext_grant));

  // R3: a show strobe always follows a sampled transfer
  assert_show_after_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    show_stb |-> $past(xfer_valid));

  // R4: no grant ever starts from the no-arbitration mode
  assert_no_grant_mode01_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_grant) |-> $past(mode_cur) != 2'b01);

  // R6: grants start only at an idle boundary
  assert_grant_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_grant) |-> $past(!xfer_valid && !show_stb));

  // R8: halt only accompanies a grant
  assert_halt_with_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_halt |-> ext_grant);

  // R9: mode changes only between transfers
  assert_mode_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_cur) |-> $past(!xfer_valid && !show_stb));

endmodule

bind showcyc_ctrl showcyc_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_valid (xfer_valid),
  .show_stb   (show_stb),
  .ext_addr_oe(ext_addr_oe),
  .ext_data_oe(ext_data_oe),
  .ext_grant  (ext_grant),
  .int_halt   (int_halt),
  .mode_cur   (mode_q)
);

// File: tb/showcyc_ctrl_test.sv
module showcyc_ctrl_test;

  localparam int AW = 12;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic [1:0]    mode_sel;
  logic          xfer_valid;
  logic [AW-1:0] xfer_addr;
  logic [DW-1:0] xfer_data;
  logic          xfer_write;
  logic          ext_req;
  logic [AW-1:0] ext_addr;
  logic [DW-1:0] ext_data;
  logic          ext_write;
  logic          ext_addr_oe;
  logic          ext_data_oe;
  logic          show_stb;
  logic          ext_grant;
  logic          int_halt;

  int checks;
  int errors;

  showcyc_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .xfer_valid(xfer_valid),
    .xfer_addr(xfer_addr), .xfer_data(xfer_data), .xfer_write(xfer_write),
    .ext_req(ext_req), .ext_addr(ext_addr), .ext_data(ext_data),
    .ext_write(ext_write), .ext_addr_oe(ext_addr_oe), .ext_data_oe(ext_data_oe),
    .show_stb(show_stb), .ext_grant(ext_grant), .int_halt(int_halt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [3:0]    tag;
    logic [1:0]    mode;
    logic          x;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          wr;
    logic          req;
    logic          es;
    logic          eg;
    logic          eh;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  2'b00, 1'b0, 12'h000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd2,  2'b00, 1'b1, 12'h123, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd9,  2'b10, 1'b0, 12'h000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd3,  2'b10, 1'b1, 12'hABC, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{4'd6,  2'b10, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd5,  2'b10, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{4'd7,  2'b10, 1'b1, 12'h777, 8'h77, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{4'd5,  2'b10, 1'b0, 12'h000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd9,  2'b11, 1'b0, 12'h000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd8,  2'b11, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{4'd8,  2'b11, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{4'd8,  2'b11, 1'b0, 12'h000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd9,  2'b01, 1'b0, 12'h000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd4,  2'b01, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd3,  2'b01, 1'b1, 12'h055, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{4'd4,  2'b01, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd9,  2'b00, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd5,  2'b00, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{4'd5,  2'b00, 1'b0, 12'h000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic x, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic wr, input logic rq);
    mode_sel   = m;
    xfer_valid = x;
    xfer_addr  = a;
    xfer_data  = d;
    xfer_write = wr;
    ext_req    = rq;
    @(posedge clk);
    #2;
  endtask

  task automatic expect_out(input string req, input logic es, input logic eg,
                            input logic eh);
    check(req, "show_stb", 32'(show_stb), 32'(es));
    check(req, "addr_oe", 32'(ext_addr_oe), 32'(es));
    check(req, "data_oe", 32'(ext_data_oe), 32'(es));
    check(req, "grant", 32'(ext_grant), 32'(eg));
    check(req, "halt", 32'(int_halt), 32'(eh));
  endtask

  task automatic expect_bus(input string req, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input logic wr);
    check(req, "ext_addr", 32'(ext_addr), 32'(a));
    check(req, "ext_data", 32'(ext_data), 32'(d));
    check(req, "ext_write", 32'(ext_write), 32'(wr));
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    mode_sel = 2'b11; xfer_valid = 1'b1; xfer_addr = '0; xfer_data = '0;
    xfer_write = 1'b0; ext_req = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    expect_out("R1", 1'b0, 1'b0, 1'b0);  // R1: outputs held low in reset
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first edge after reset uses mode 00, so no show despite the strobe
    step(2'b00, 1'b1, 12'h321, 8'h11, 1'b1, 1'b0);
    expect_out("R1", 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].mode, VECS[i].x, VECS[i].a, VECS[i].d, VECS[i].wr, VECS[i].req);
      expect_out(tag_name(VECS[i].tag), VECS[i].es, VECS[i].eg, VECS[i].eh);
      if (VECS[i].es) expect_bus(tag_name(VECS[i].tag), VECS[i].a, VECS[i].d, VECS[i].wr);
    end

    // R10: back-to-back transfers in mode 10
    step(2'b10, 1'b0, '0, '0, 1'b0, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      step(2'b10, 1'b1, 12'(k * 12'h111), 8'(k * 8'h21), k[0], 1'b0);
      expect_out("R10", 1'b1, 1'b0, 1'b0);
      expect_bus("R10", 12'(k * 12'h111), 8'(k * 8'h21), k[0]);
    end
    step(2'b10, 1'b0, '0, '0, 1'b0, 1'b0);
    expect_out("R10", 1'b0, 1'b0, 1'b0);

    // R9: mode 00 requested during transfers is deferred
    step(2'b00, 1'b1, 12'h444, 8'h44, 1'b0, 1'b0);
    expect_out("R9", 1'b1, 1'b0, 1'b0);
    step(2'b00, 1'b1, 12'h555, 8'h55, 1'b1, 1'b0);
    expect_out("R9", 1'b1, 1'b0, 1'b0);
    expect_bus("R9", 12'h555, 8'h55, 1'b1);
    step(2'b00, 1'b0, '0, '0, 1'b0, 1'b0);
    step(2'b00, 1'b0, '0, '0, 1'b0, 1'b0);
    step(2'b00, 1'b1, 12'h666, 8'h66, 1'b0, 1'b0);
    expect_out("R9", 1'b0, 1'b0, 1'b0);

    // R6: request together with a strobe waits for the boundary
    step(2'b00, 1'b1, 12'h010, 8'h01, 1'b0, 1'b1);
    expect_out("R6", 1'b0, 1'b0, 1'b0);
    step(2'b00, 1'b0, '0, '0, 1'b0, 1'b1);
    expect_out("R6", 1'b0, 1'b1, 1'b0);
    step(2'b00, 1'b0, '0, '0, 1'b0, 1'b0);
    expect_out("R5", 1'b0, 1'b0, 1'b0);

    // R9: switching to mode 01 withdraws a held grant
    step(2'b10, 1'b0, '0, '0, 1'b0, 1'b0);
    step(2'b10, 1'b0, '0, '0, 1'b0, 1'b1);
    expect_out("R9", 1'b0, 1'b1, 1'b0);
    step(2'b01, 1'b0, '0, '0, 1'b0, 1'b1);
    expect_out("R9", 1'b0, 1'b1, 1'b0);
    step(2'b01, 1'b0, '0, '0, 1'b0, 1'b1);
    expect_out("R9", 1'b0, 1'b0, 1'b0);
    step(2'b01, 1'b0, '0, '0, 1'b0, 1'b1);
    expect_out("R4", 1'b0, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule